// File: doc/BRIEF.md
# Bus Master Watchdog Timeout Monitor

This block sits beside the master side of a parallel PCI bus interface and watches for two ways a transaction can hang. The first is a data phase in which the target keeps the master waiting for TRDY too long. The second is a transfer that the target keeps terminating with retry more often than allowed. When either happens, the block sets a sticky unrecoverable-error flag. The flag stays set until software clears it with a one-cycle strobe.

Two 8-bit limit registers set the thresholds. Software writes and reads them through a small synchronous register port at offsets 40h (wait limit) and 41h (retry limit). The wait limit is coarse: the register value is the upper eight bits of a 13-bit cycle count, so one step is 32 clocks. A register value of zero turns off its watchdog. A timeout is declared only when a count becomes strictly greater than its limit. Reaching the limit exactly is still legal.

Top module: `pci_wdog_top`

## Requirements
- R1: After synchronous reset, offset 40h reads 00h, offset 41h reads 80h, and any other offset reads 00h; `ue` is 0.
- R2: A write strobe to offset 40h or 41h updates that register, and the new value is visible on `cfg_rdata` from the next cycle. A write to any other offset changes neither register.
- R3: With wait register value W≠0, the limit is W×32 clocks. If `dp_wait` is high without `trdy_seen` for exactly W×32 consecutive clocks, `ue` stays 0. If it is held for W×32+1 clocks, `ue` becomes 1 one cycle after the count first exceeds the limit.
- R4: A wait register value of 00h disables the wait watchdog: no length of waiting sets `ue`.
- R5: The wait count restarts from zero whenever `trdy_seen` is high or `dp_wait` is low, so separate waits that are each within the limit never add up to a timeout.
- R6: With retry register value N≠0, N `retry_term` pulses without an intervening `trdy_seen` leave `ue` at 0. N+1 such pulses set `ue` one cycle after the count exceeds N.
- R7: A retry register value of 00h disables the retry watchdog.
- R8: A `trdy_seen` pulse, meaning completion without a retry, resets the retry count to zero.
- R9: `ue` is sticky. It is cleared by `ue_clr` on the next clock edge, except that a timeout in the same cycle takes priority and keeps it set.
- R10: The wait count saturates at 8191 instead of wrapping. A wait longer than 8192 clocks, with the limit then raised to FFh (8160), still sets `ue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| dp_wait | input | 1 | High for each clock the master spends in a data phase waiting for the target |
| trdy_seen | input | 1 | Target ready sampled asserted (data transferred) |
| retry_term | input | 1 | One-cycle pulse: target ended the transaction with retry |
| ue_clr | input | 1 | Software clear of the error flag |
| ue | output | 1 | Sticky unrecoverable-error flag |

## Verification
The wait watchdog is driven with single bursts of exactly the limit and one clock past it, at two register values. This shows a strict comparison and confirms that the register is scaled by 32. Split bursts, separated either by a dropped wait or by a TRDY pulse inside a continuous wait, show that the count restarts. A very long wait with the check disabled and then re-enabled at the maximum tells saturation apart from wrap-around. Retry sequences of length N and N+1, and two short runs split by a completion, separate the threshold from count clearing. A clear strobe issued together with a firing timeout checks the set-over-clear priority.

// File: rtl/pci_wdog_pkg.sv
package pci_wdog_pkg;

    localparam int WD_CFG_W   = 8;
    localparam int WD_SHIFT   = 5;
    localparam int WD_ADDR_W  = 8;

    localparam logic [WD_ADDR_W-1:0] WD_WAIT_OFS  = 8'h40;
    localparam logic [WD_ADDR_W-1:0] WD_RETRY_OFS = 8'h41;
    localparam logic [WD_CFG_W-1:0]  WD_WAIT_RST  = 8'h00;
    localparam logic [WD_CFG_W-1:0]  WD_RETRY_RST = 8'h80;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_WAIT  = 2'd1,
        SEL_RETRY = 2'd2
    } wd_sel_e;

    typedef struct packed {
        logic [WD_CFG_W-1:0] wait_lim;
        logic [WD_CFG_W-1:0] retry_lim;
    } wd_cfg_t;

    typedef struct packed {
        logic wait_phase;
        logic ready;
        logic retry;
    } wd_evt_t;

    typedef struct packed {
        logic wait_to;
        logic retry_to;
    } wd_hit_t;

    function automatic logic [WD_CFG_W+WD_SHIFT-1:0] wd_scale(input logic [WD_CFG_W-1:0] v);
        return {v, {WD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/wd_cfg_regs.sv
module wd_cfg_regs
    import pci_wdog_pkg::*;
#(
    parameter int                  ADDR_W    = WD_ADDR_W,
    parameter int                  CFG_W     = WD_CFG_W,
    parameter logic [ADDR_W-1:0]   WAIT_OFS  = WD_WAIT_OFS,
    parameter logic [ADDR_W-1:0]   RETRY_OFS = WD_RETRY_OFS,
    parameter logic [CFG_W-1:0]    WAIT_RST  = WD_WAIT_RST,
    parameter logic [CFG_W-1:0]    RETRY_RST = WD_RETRY_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [CFG_W-1:0]  wait_lim,
    output logic [CFG_W-1:0]  retry_lim
);

    wd_sel_e            sel;
    logic [CFG_W-1:0]   wait_q;
    logic [CFG_W-1:0]   retry_q;

    always_comb begin
        if (addr == WAIT_OFS)       sel = SEL_WAIT;
        else if (addr == RETRY_OFS) sel = SEL_RETRY;
        else                        sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= WAIT_RST;
            retry_q <= RETRY_RST;
        end else if (wr_en) begin
            case (sel)
                SEL_WAIT:  wait_q  <= wdata;
                SEL_RETRY: retry_q <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_WAIT:  rdata = wait_q;
            SEL_RETRY: rdata = retry_q;
            default:   rdata = '0;
        endcase
    end

    assign wait_lim  = wait_q;
    assign retry_lim = retry_q;

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (wait_q == WAIT_RST && retry_q == RETRY_RST));

    // R2: foreign offsets leave both registers alone
    p_foreign_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> ($stable(wait_q) && $stable(retry_q)));

endmodule

// File: rtl/wd_wait_timer.sv
module wd_wait_timer
    import pci_wdog_pkg::*;
#(
    parameter int CFG_W = WD_CFG_W,
    parameter int SHIFT = WD_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] lim_reg,
    input  logic             wait_phase,
    input  logic             ready,
    output logic             timeout
);

    localparam int               CNT_W   = CFG_W + SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             armed;

    assign limit = {lim_reg, {SHIFT{1'b0}}};
    assign armed = |lim_reg;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (ready || !wait_phase) cnt <= '0;
        else if (cnt != CNT_MAX)       cnt <= cnt + 1'b1;
    end

    assign timeout = armed && (cnt > limit);

    // R3: each waiting clock advances the count by one
    p_wait_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wait_phase && !ready && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R5: ready restarts the count
    p_wait_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ready |=> (cnt == '0));

    // R10: saturation instead of wrap
    p_wait_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && wait_phase && !ready) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/wd_retry_count.sv
module wd_retry_count
    import pci_wdog_pkg::*;
#(
    parameter int CFG_W = WD_CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] lim_reg,
    input  logic             retry,
    input  logic             ready,
    output logic             timeout
);

    localparam int               CNT_W   = CFG_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (ready)                   cnt <= '0;
        else if (retry && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign timeout = (|lim_reg) && (cnt > {1'b0, lim_reg});

    // R6: each retry pulse advances the count
    p_retry_step_r6: assert property (@(posedge clk) disable iff (rst)
        (retry && !ready && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8: completion clears the retry count
    p_retry_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ready |=> (cnt == '0));

endmodule

// File: rtl/pci_wdog_top.sv
module pci_wdog_top
    import pci_wdog_pkg::*;
#(
    parameter int                  ADDR_W    = WD_ADDR_W,
    parameter int                  CFG_W     = WD_CFG_W,
    parameter int                  SHIFT     = WD_SHIFT,
    parameter logic [ADDR_W-1:0]   WAIT_OFS  = WD_WAIT_OFS,
    parameter logic [ADDR_W-1:0]   RETRY_OFS = WD_RETRY_OFS,
    parameter logic [CFG_W-1:0]    WAIT_RST  = WD_WAIT_RST,
    parameter logic [CFG_W-1:0]    RETRY_RST = WD_RETRY_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              dp_wait,
    input  logic              trdy_seen,
    input  logic              retry_term,
    input  logic              ue_clr,
    output logic              ue
);

    wd_evt_t evt;
    wd_hit_t hit;
    logic [CFG_W-1:0] wait_lim;
    logic [CFG_W-1:0] retry_lim;
    logic ue_q;

    assign evt = '{wait_phase: dp_wait, ready: trdy_seen, retry: retry_term};

    wd_cfg_regs #(
        .ADDR_W(ADDR_W), .CFG_W(CFG_W),
        .WAIT_OFS(WAIT_OFS), .RETRY_OFS(RETRY_OFS),
        .WAIT_RST(WAIT_RST), .RETRY_RST(RETRY_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .wait_lim(wait_lim), .retry_lim(retry_lim)
    );

    wd_wait_timer #(.CFG_W(CFG_W), .SHIFT(SHIFT)) u_wait (
        .clk(clk), .rst(rst), .lim_reg(wait_lim),
        .wait_phase(evt.wait_phase), .ready(evt.ready),
        .timeout(hit.wait_to)
    );

    wd_retry_count #(.CFG_W(CFG_W)) u_retry (
        .clk(clk), .rst(rst), .lim_reg(retry_lim),
        .retry(evt.retry), .ready(evt.ready),
        .timeout(hit.retry_to)
    );

    always_ff @(posedge clk) begin
        if (rst)                          ue_q <= 1'b0;
        else if (hit.wait_to || hit.retry_to) ue_q <= 1'b1;
        else if (ue_clr)                  ue_q <= 1'b0;
    end

    assign ue = ue_q;

    // R3: a wait timeout reaches the flag on the next edge
    p_wait_sets_ue_r3: assert property (@(posedge clk) disable iff (rst)
        hit.wait_to |=> ue);

    // R6: a retry timeout reaches the flag on the next edge
    p_retry_sets_ue_r6: assert property (@(posedge clk) disable iff (rst)
        hit.retry_to |=> ue);

    // R9: sticky without a clear
    p_ue_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ue && !ue_clr) |=> ue);

    // R9: clear works when no timeout competes
    p_ue_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ue_clr && !hit.wait_to && !hit.retry_to) |=> !ue);

endmodule

// File: tb/test_pci_wdog_top.sv
module test_pci_wdog_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       dp_wait = 1'b0;
    logic       trdy_seen = 1'b0;
    logic       retry_term = 1'b0;
    logic       ue_clr = 1'b0;
    logic       ue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_reg;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_wdog_top i_pci_wdog_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dp_wait(dp_wait),
        .trdy_seen(trdy_seen), .retry_term(retry_term), .ue_clr(ue_clr), .ue(ue)
    );

    // Monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            act = it.is_reg ? cfg_rdata : {7'd0, ue};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_ue(input logic e, input string req);
        sbq.push_back('{is_reg: 1'b0, exp: {7'd0, e}, req: req});
        @(negedge clk);
        #1;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string req);
        cfg_addr = a;
        sbq.push_back('{is_reg: 1'b1, exp: e, req: req});
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    // Wait burst of n clocks; optionally hold the clear strobe through it and one edge after
    task automatic burst(input int n, input bit clr);
        dp_wait = 1'b1; ue_clr = clr;
        tick(n);
        dp_wait = 1'b0;
        tick();
        ue_clr = 1'b0;
    endtask

    task automatic retries(input int n);
        for (int i = 0; i < n; i++) begin
            retry_term = 1'b1; tick();
            retry_term = 1'b0; tick();
        end
    endtask

    task automatic complete();
        trdy_seen = 1'b1; tick(); trdy_seen = 1'b0; tick();
    endtask

    task automatic clear_ue();
        ue_clr = 1'b1; tick(); ue_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();

        // R1: reset state
        chk_rd(8'h40, 8'h00, "R1 wait reg reset");
        chk_rd(8'h41, 8'h80, "R1 retry reg reset");
        chk_rd(8'h42, 8'h00, "R1 unmapped read");
        chk_ue(1'b0, "R1 ue reset");

        // R2: register access
        wr(8'h40, 8'h03);
        chk_rd(8'h40, 8'h03, "R2 wait reg write");
        wr(8'h41, 8'h05);
        chk_rd(8'h41, 8'h05, "R2 retry reg write");
        wr(8'h7F, 8'hAA);
        chk_rd(8'h40, 8'h03, "R2 foreign write wait");
        chk_rd(8'h41, 8'h05, "R2 foreign write retry");
        chk_rd(8'h7F, 8'h00, "R2 foreign read");

        // R3: limit 32
        wr(8'h40, 8'h01);
        burst(32, 1'b0); tick();
        chk_ue(1'b0, "R3 wait equal to limit 32");
        burst(33, 1'b0); tick();
        chk_ue(1'b1, "R3 wait past limit 32");

        // R9: sticky then clear
        tick(5);
        chk_ue(1'b1, "R9 sticky");
        clear_ue();
        chk_ue(1'b0, "R9 cleared");

        // R9: timeout wins over a simultaneous clear
        burst(33, 1'b1);
        chk_ue(1'b1, "R9 set beats clear");
        clear_ue();
        chk_ue(1'b0, "R9 cleared after priority");

        // R3: limit 64
        wr(8'h40, 8'h02);
        burst(64, 1'b0); tick();
        chk_ue(1'b0, "R3 wait equal to limit 64");
        burst(65, 1'b0); tick();
        chk_ue(1'b1, "R3 wait past limit 64");
        clear_ue();

        // R5: split waits do not accumulate
        wr(8'h40, 8'h01);
        burst(20, 1'b0);
        burst(20, 1'b0); tick();
        chk_ue(1'b0, "R5 gap restarts count");
        dp_wait = 1'b1; tick(20);
        trdy_seen = 1'b1; tick(); trdy_seen = 1'b0;
        tick(20); dp_wait = 1'b0; tick(2);
        chk_ue(1'b0, "R5 ready restarts count");

        // R4: disabled wait check
        wr(8'h40, 8'h00);
        burst(300, 1'b0); tick();
        chk_ue(1'b0, "R4 wait check disabled");

        // R10: saturation
        dp_wait = 1'b1;
        tick(8300);
        wr(8'h40, 8'hFF);
        tick(2);
        chk_ue(1'b1, "R10 saturated count exceeds 8160");
        dp_wait = 1'b0; tick();
        wr(8'h40, 8'h00);
        clear_ue();
        chk_ue(1'b0, "R10 cleared");

        // R6: retry limit 3
        wr(8'h41, 8'h03);
        retries(3); tick();
        chk_ue(1'b0, "R6 retries equal to limit");
        complete();
        retries(4); tick();
        chk_ue(1'b1, "R6 retries past limit");
        complete();
        clear_ue();
        chk_ue(1'b0, "R6 cleared");

        // R8: completion clears retry count
        retries(2);
        complete();
        retries(2); tick();
        chk_ue(1'b0, "R8 completion restarts retries");
        complete();

        // R7: retry check disabled
        wr(8'h41, 8'h00);
        retries(20); tick();
        chk_ue(1'b0, "R7 retry check disabled");
        complete();

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule